// File: doc/BRIEF.md
# Dual-Channel Wiper Code Controller

This block holds the two 8-bit wiper codes of a dual 256-step digital potentiometer and updates them from a serial peripheral interface (SPI) link. A controller lowers chip select and shifts a 16-bit frame in, most significant bit first. The SPI clock is sampled on the rising edge. The upper byte of the frame is a command and the lower byte is a data value. When chip select returns high after exactly sixteen clock pulses, the frame is decoded. It either loads the data byte into one or both channels or places the selected channels in shutdown. A frame of any other length is dropped.

Every SPI pin is oversampled by the block clock through a synchronizer, so the serial clock must run well below the block clock. Two pins act asynchronously on the whole block. A low preset pin forces both codes to the mid-scale value 0x80. A low hold-off pin reports every channel as shut down while it is low, and it leaves the stored codes as they are. The serial output returns the bits that were in the shift register before the frame began, so several devices can be chained on one link. Code 0x00 places a wiper at the B end. A channel flagged off has its A end open and its wiper tied to B in the analog part, which lies outside this block.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: A synchronous reset sets both wiper codes to 0x80, clears both off flags and drives spi_miso low.
- R2: A valid frame whose command bits [13:12] are 01 copies frame bits [7:0] into every channel whose mask bit is set. Frame bit 8 selects channel 0 and frame bit 9 selects channel 1. Channels whose mask bit is clear keep their codes.
- R3: A valid frame whose command bits [13:12] are 10 sets the off flag of every masked channel and leaves both codes unchanged.
- R4: A write to a channel that is off clears that channel's off flag.
- R5: A valid frame whose command bits [13:12] are 00 or 11 changes no code and no flag.
- R6: A frame is applied only when chip select rises after exactly 16 SPI clock rising edges. Frames of 15 or 17 edges are discarded.
- R7: While preset_n is low, both codes read 0x80 and the off flags keep their values.
- R8: While hold_off_n is low, chan_off reads all ones and the codes are unchanged. After hold_off_n is released, chan_off again shows the flags set by commands.
- R9: spi_miso presents the shift register MSB. It is loaded when chip select falls and updated after each SPI clock falling edge, so a frame shifted in reappears bit for bit, MSB first, during the next frame.
- R10: wiper_code carries channel 0 in bits [7:0] and channel 1 in bits [15:8]. chan_off carries channel 0 in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all SPI pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out for chaining |
| preset_n | input | 1 | Active-low force of both codes to mid-scale |
| hold_off_n | input | 1 | Active-low shutdown of all channels |
| wiper_code | output | 16 | Channel 1 code in [15:8], channel 0 code in [7:0] |
| chan_off | output | 2 | Per-channel shutdown flag |

## Verification
Write frames are sent with masks that select each single channel and then both channels. This separates correct mask decoding from swapped or merged channel enables. Shutdown and no-op opcodes are sent with the same masks, which shows whether the opcode field is decoded separately from the mask field. Frames of 15 and 17 clocks carry commands that would visibly change the codes, so a counter that accepts the wrong length shows up at once. A known frame followed by a second frame shows whether the chained output keeps the bit order and the timing of its updates.

// File: rtl/dual_wiper_pkg.sv
package dual_wiper_pkg;
  // Operation field decoded from command bits [5:4]
  typedef enum logic [1:0] {
    OP_IDLE_A = 2'b00,
    OP_LOAD   = 2'b01,
    OP_SLEEP  = 2'b10,
    OP_IDLE_B = 2'b11
  } wiper_op_e;

  localparam int OP_FIELD_LSB = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= IDLE;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_ok,
  output logic               miso,
  output logic               sck_fall,
  output logic               cs_fall
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic               sck_d, cs_d;
  logic               sck_rise, cs_rise;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   edge_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
    end
  end

  assign sck_rise = sck_s  & ~sck_d & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_d  & ~cs_n_s;
  assign cs_fall  = ~cs_n_s & cs_d;
  assign cs_rise  = cs_n_s  & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      edge_cnt <= '0;
      miso     <= 1'b0;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= cs_rise && (edge_cnt == CNT_W'(FRAME_W));
      if (cs_fall) begin
        edge_cnt <= '0;
        miso     <= shreg[FRAME_W-1];
      end else begin
        if (sck_rise) begin
          shreg <= {shreg[FRAME_W-2:0], mosi_s};
          if (edge_cnt != CNT_W'(CNT_SAT)) edge_cnt <= edge_cnt + 1'b1;
        end
        if (sck_fall) miso <= shreg[FRAME_W-1];
      end
    end
  end

  assign frame = shreg;
endmodule

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import dual_wiper_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_CH  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_ok,
  input  logic [FRAME_W-1:0] frame,
  output logic [NUM_CH-1:0]  wr_mask,
  output logic [NUM_CH-1:0]  sd_mask,
  output logic [DATA_W-1:0]  wr_data
);
  localparam int CMD_W = FRAME_W - DATA_W;

  logic [CMD_W-1:0]  cmd;
  wiper_op_e         op;
  logic [NUM_CH-1:0] sel;

  assign cmd = frame[FRAME_W-1:DATA_W];
  assign op  = wiper_op_e'(cmd[OP_FIELD_LSB+1:OP_FIELD_LSB]);
  assign sel = cmd[NUM_CH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mask <= '0;
      sd_mask <= '0;
      wr_data <= '0;
    end else begin
      wr_mask <= '0;
      sd_mask <= '0;
      if (frame_ok) begin
        wr_data <= frame[DATA_W-1:0];
        case (op)
          OP_LOAD:  wr_mask <= sel;
          OP_SLEEP: sd_mask <= sel;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2,
  parameter logic [DATA_W-1:0] MID = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     preset_n_s,
  input  logic                     hold_off_n_s,
  input  logic [NUM_CH-1:0]        wr_mask,
  input  logic [NUM_CH-1:0]        sd_mask,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] codes,
  output logic [NUM_CH-1:0]        off
);
  logic [NUM_CH-1:0] sleep_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst || !preset_n_s) codes[c*DATA_W +: DATA_W] <= MID;
        else if (wr_mask[c])    codes[c*DATA_W +: DATA_W] <= wr_data;
      end

      always_ff @(posedge clk) begin
        if (rst)             sleep_q[c] <= 1'b0;
        else if (wr_mask[c]) sleep_q[c] <= 1'b0;
        else if (sd_mask[c]) sleep_q[c] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst) off[c] <= 1'b0;
        else     off[c] <= sleep_q[c] | ~hold_off_n_s;
      end
    end
  endgenerate
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
  parameter int DATA_W      = 8,
  parameter int NUM_CH      = 2,
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     spi_sck,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic                     preset_n,
  input  logic                     hold_off_n,
  output logic [NUM_CH*DATA_W-1:0] wiper_code,
  output logic [NUM_CH-1:0]        chan_off
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [4:0]         pins_s;
  logic               sck_s, cs_n_s, mosi_s, preset_n_s, hold_off_n_s;
  logic [FRAME_W-1:0] frame;
  logic               frame_ok, sck_fall, cs_fall;
  logic [NUM_CH-1:0]  wr_mask, sd_mask;
  logic [DATA_W-1:0]  wr_data;

  pin_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .IDLE(5'b11010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hold_off_n, preset_n, spi_cs_n, spi_mosi, spi_sck}),
    .q   (pins_s)
  );
  assign {hold_off_n_s, preset_n_s, cs_n_s, mosi_s, sck_s} = pins_s;

  spi_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s),
    .frame    (frame),
    .frame_ok (frame_ok),
    .miso     (spi_miso),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall)
  );

  wiper_cmd_decode #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .frame_ok (frame_ok),
    .frame    (frame),
    .wr_mask  (wr_mask),
    .sd_mask  (sd_mask),
    .wr_data  (wr_data)
  );

  wiper_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .MID(MID_CODE)) u_bank (
    .clk          (clk),
    .rst          (rst),
    .preset_n_s   (preset_n_s),
    .hold_off_n_s (hold_off_n_s),
    .wr_mask      (wr_mask),
    .sd_mask      (sd_mask),
    .wr_data      (wr_data),
    .codes        (wiper_code),
    .off          (chan_off)
  );
endmodule

// File: rtl/dual_wiper_ctrl_chk.sv
module dual_wiper_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     spi_miso,
  input logic [NUM_CH*DATA_W-1:0] wiper_code,
  input logic [NUM_CH-1:0]        chan_off,
  input logic                     preset_n_s,
  input logic                     hold_off_n_s,
  input logic [NUM_CH-1:0]        wr_mask,
  input logic                     frame_ok,
  input logic                     sck_fall,
  input logic                     cs_fall
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  // R1
  reset_mid_chk: assert property (@(posedge clk)
    rst |=> (wiper_code == {NUM_CH{MID}}) && (chan_off == '0));

  // R7
  preset_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !preset_n_s |=> wiper_code == {NUM_CH{MID}});

  // R8
  hold_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_off_n_s |=> &chan_off);

  // R5
  codes_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (preset_n_s && wr_mask == '0) |=> $stable(wiper_code));

  // R9
  miso_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !(sck_fall || cs_fall) |=> $stable(spi_miso));

  // R6
  frame_gate_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok);
endmodule

bind dual_wiper_ctrl dual_wiper_ctrl_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .spi_miso     (spi_miso),
  .wiper_code   (wiper_code),
  .chan_off     (chan_off),
  .preset_n_s   (preset_n_s),
  .hold_off_n_s (hold_off_n_s),
  .wr_mask      (wr_mask),
  .frame_ok     (frame_ok),
  .sck_fall     (sck_fall),
  .cs_fall      (cs_fall)
);

// File: tb/dual_wiper_ctrl_bench.sv
module dual_wiper_ctrl_bench;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        preset_n = 1'b1, hold_off_n = 1'b1;
  logic        spi_miso;
  logic [15:0] wiper_code;
  logic [1:0]  chan_off;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  dual_wiper_ctrl u_dual_wiper_ctrl (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .preset_n(preset_n),
    .hold_off_n(hold_off_n), .wiper_code(wiper_code), .chan_off(chan_off)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n, output logic [31:0] got);
    got = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < n; i++) begin
      spi_mosi = bits[n-1-i];
      idle(HALF);
      got = {got[30:0], spi_miso};
      spi_sck = 1'b1;
      idle(HALF);
      spi_sck = 1'b0;
    end
    idle(HALF);
    spi_cs_n = 1'b1;
    idle(12);
  endtask

  task automatic frame16(input logic [15:0] f);
    logic [31:0] g;
    send({16'h0, f}, 16, g);
  endtask

  task automatic t_reset;
    chk("R1 codes", 32'(wiper_code), 32'h8080);
    chk("R1 off", 32'(chan_off), 32'h0);
    chk("R1 miso", 32'(spi_miso), 32'h0);
  endtask

  task automatic t_write;
    frame16(16'h1111);
    chk("R2 ch0 only", 32'(wiper_code), 32'h8011);
    frame16(16'h1300);
    chk("R2 both", 32'(wiper_code), 32'h0000);
    frame16(16'h12FF);
    chk("R10 ch1 only", 32'(wiper_code), 32'hFF00);
  endtask

  task automatic t_shutdown;
    frame16(16'h2199);
    chk("R3 off ch0", 32'(chan_off), 32'h1);
    chk("R3 codes kept", 32'(wiper_code), 32'hFF00);
  endtask

  task automatic t_wake;
    frame16(16'h1155);
    chk("R4 wake ch0", 32'(chan_off), 32'h0);
    chk("R4 code", 32'(wiper_code), 32'hFF55);
    frame16(16'h2300);
    chk("R3 both off", 32'(chan_off), 32'h3);
    frame16(16'h1277);
    chk("R4 wake ch1", 32'(chan_off), 32'h1);
    chk("R4 code ch1", 32'(wiper_code), 32'h7755);
  endtask

  task automatic t_nop;
    frame16(16'h33AA);
    frame16(16'h03AA);
    frame16(16'hC3AA);
    chk("R5 codes", 32'(wiper_code), 32'h7755);
    chk("R5 flags", 32'(chan_off), 32'h1);
  endtask

  task automatic t_bad_len;
    logic [31:0] g;
    send(32'h000013AA >> 1, 15, g);
    chk("R6 short", 32'(wiper_code), 32'h7755);
    send(32'h000013AA << 1, 17, g);
    chk("R6 long", 32'(wiper_code), 32'h7755);
    chk("R6 flags", 32'(chan_off), 32'h1);
  endtask

  task automatic t_preset;
    preset_n = 1'b0;
    idle(8);
    chk("R7 mid", 32'(wiper_code), 32'h8080);
    chk("R7 flags kept", 32'(chan_off), 32'h1);
    preset_n = 1'b1;
    idle(8);
  endtask

  task automatic t_hold;
    hold_off_n = 1'b0;
    idle(8);
    chk("R8 all off", 32'(chan_off), 32'h3);
    chk("R8 codes kept", 32'(wiper_code), 32'h8080);
    hold_off_n = 1'b1;
    idle(8);
    chk("R8 release", 32'(chan_off), 32'h1);
  endtask

  task automatic t_chain;
    logic [31:0] g;
    frame16(16'h0F5A);
    send(32'h000030C3, 16, g);
    chk("R9 chained bits", g, 32'h00000F5A);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(5);
    t_reset();
    t_write();
    t_shutdown();
    t_wake();
    t_nop();
    t_bad_len();
    t_preset();
    t_hold();
    t_chain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule